// File: doc/BRIEF.md
# Dual-Mode Bit-Serial HDLC Transmitter

This block drives one 64 kbit/s bearer channel with a single serial output bit. Software writes bytes into a small transmit FIFO through an 8-bit register port, picks the operating mode, and issues two self-clearing commands: end-of-message and transmitter reset. A one-cycle bit-enable strobe paces the line, and each strobe advances the output by exactly one bit. Bytes leave least significant bit first.

In framed mode the block builds a complete HDLC frame. It sends an opening flag, then the data with zero-bit insertion, then a complemented CRC-16 check sequence, then a closing flag. Between frames it sends either continuous ones or repeated flags, chosen by a register bit. In raw mode the FIFO contents go out unchanged, and the line idles at all ones. The end-of-message command closes the current frame in framed mode. In raw mode it stops data transmission and discards whatever is still queued.

Top module: `hdlc_dual_tx`

## Requirements
- R1: After the asynchronous reset, `tx_bit` is 1, the mode register reads 00h, and `tx_ready` is 1.
- R2: `tx_bit` changes only on the clock edge where `bit_en` is high, or on the edge that applies the reset command. Each strobe emits one bit, and bytes leave LSB first.
- R3: In framed mode (mode bit0 = 0), a frame is the flag 01111110, then the data bytes, then a 16-bit check sequence, then a closing flag. The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, preset to FFFFh, computed LSB first. It is sent complemented, low byte first, LSB first. A frame starts at the next 8-bit fill boundary once the FIFO is non-empty and either end-of-message is pending or the FIFO is full.
- R4: In framed mode, a 0 is inserted after every run of five consecutive 1s in the data and check fields. This includes a run that ends on the last check bit. No insertion is made inside flags.
- R5: The framed-mode fill is selected by mode bit1. With bit1 = 0 the fill is continuous 1s. With bit1 = 1 the fill is back-to-back 01111110 flags, aligned to 8-bit boundaries counted from the reset command.
- R6: In raw mode (mode bit1 ignored, bit0 = 1), queued bytes are sent unaltered and back-to-back, starting at the next 8-bit boundary. The idle line is all 1s.
- R7: In raw mode, an end-of-message command lets the byte in flight finish. The block then discards the rest of the FIFO and returns the line to all 1s.
- R8: In framed mode, if the FIFO runs empty during a frame, the frame is closed with its check sequence and a closing flag, whether or not end-of-message was issued.
- R9: The reset command (command bit1) empties the FIFO and sets the line to fill. Pending end-of-message is dropped. On the next cycle `tx_ready` is 1.
- R10: The register map is as follows. Address 0 is a FIFO push. Address 1 is the mode register, which can be read back. Address 2 holds the commands, bit0 end-of-message and bit1 reset; these clear themselves and always read 0. Address 3 is status, with bit0 equal to `tx_ready`.
- R11: `tx_ready` is 1 while the FIFO holds at most half its depth. A push into a full FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe that advances the line by one bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| tx_ready | output | 1 | FIFO has room (at most half full) |
| tx_bit | output | 1 | Serial line output |

## Verification
Most internal faults show up in the serial stream within one or two bytes. A miscounted bit counter or stuffing counter, for example, breaks a frame's bit alignment, and every bit after the fault then differs from the expected stream. A wrong check-sequence register appears only in the 16 check bits just before the closing flag. A FIFO pointer fault shows up as a repeated or missing data byte, or as the wrong `tx_ready` level on the next push. The bench therefore compares whole captured streams bit by bit against frames it builds itself, so it can report the first bit position where the stream departs.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_CRC, ST_CLOSE, ST_RAW
  } tx_state_e;

  localparam logic [1:0]  A_DATA = 2'd0;
  localparam logic [1:0]  A_MODE = 2'd1;
  localparam logic [1:0]  A_CMD  = 2'd2;
  localparam logic [1:0]  A_STAT = 2'd3;

  localparam logic [7:0]  FLAG_PAT  = 8'h7E;
  localparam logic [15:0] CRC_POLY  = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
endpackage

// File: rtl/hdlc_tx_regs.sv
module hdlc_tx_regs
  import hdlc_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          tx_ready,
  output logic [DW-1:0] reg_rdata,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_wdata,
  output logic          raw_mode,
  output logic          fill_flag,
  output logic          cmd_eom,
  output logic          cmd_rst
);
  logic [1:0] mode_q, mode_d;
  logic       eom_q, eom_d, rst_q, rst_d;
  logic       wr_cmd;

  assign wr_cmd = reg_wr && (reg_addr == A_CMD);

  always_comb begin
    mode_d = mode_q;
    if (reg_wr && (reg_addr == A_MODE)) mode_d = reg_wdata[1:0];
    rst_d = wr_cmd && reg_wdata[1];
    eom_d = wr_cmd && reg_wdata[0] && !reg_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      eom_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      eom_q  <= eom_d;
      rst_q  <= rst_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_MODE:  reg_rdata = {{(DW-2){1'b0}}, mode_q};
      A_STAT:  reg_rdata = {{(DW-1){1'b0}}, tx_ready};
      default: reg_rdata = '0;
    endcase
  end

  assign fifo_push  = reg_wr && (reg_addr == A_DATA);
  assign fifo_wdata = reg_wdata;
  assign raw_mode   = mode_q[0];
  assign fill_flag  = mode_q[1];
  assign cmd_eom    = eom_q;
  assign cmd_rst    = rst_q;
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DW-1:0]            din,
  input  logic                     pop,
  input  logic                     flush,
  output logic [DW-1:0]            dout,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = wr_q + AW'(do_push);
      rd_d  = rd_q + AW'(do_pop);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int              W      = 16,
  parameter logic [W-1:0]    POLY   = 16'h8408,
  parameter logic [W-1:0]    PRESET = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic upd,
  input  logic shift,
  input  logic din,
  output logic lsb
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  assign fb = crc_q[0] ^ din;

  always_comb begin
    crc_d = crc_q;
    if (init)       crc_d = PRESET;
    else if (upd)   crc_d = (crc_q >> 1) ^ (fb ? POLY : '0);
    else if (shift) crc_d = crc_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= PRESET;
    else        crc_q <= crc_d;
  end

  assign lsb = crc_q[0];
endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
  import hdlc_tx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CRCW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          raw_mode,
  input  logic          fill_flag,
  input  logic          cmd_eom,
  input  logic          cmd_rst,
  input  logic [DW-1:0] fifo_dout,
  input  logic          fifo_empty,
  input  logic          fifo_full,
  output logic          fifo_pop,
  output logic          fifo_flush,
  output logic          tx_bit
);
  localparam int CNTW = $clog2(CRCW);
  localparam int BW   = $clog2(DW);
  localparam logic [CNTW-1:0] BYTE_LAST = CNTW'(DW - 1);
  localparam logic [CNTW-1:0] CRC_LAST  = CNTW'(CRCW - 1);
  localparam logic [2:0]      STUFF_RUN = 3'd5;

  tx_state_e     state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [2:0]    ones_q, ones_d;
  logic          eom_q, eom_d;
  logic          tx_q, tx_d;
  logic          crc_init, crc_upd, crc_shift, crc_din, crc_lsb;
  logic          byte_last, flag_bit, out_b;

  hdlc_tx_crc #(.W(CRCW), .POLY(CRC_POLY), .PRESET(CRC_PRESET)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .shift(crc_shift), .din(crc_din), .lsb(crc_lsb)
  );

  assign byte_last = (cnt_q == BYTE_LAST);
  assign flag_bit  = FLAG_PAT[cnt_q[BW-1:0]];

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    ones_d     = ones_q;
    eom_d      = eom_q | cmd_eom;
    tx_d       = tx_q;
    fifo_pop   = 1'b0;
    fifo_flush = 1'b0;
    crc_init   = 1'b0;
    crc_upd    = 1'b0;
    crc_shift  = 1'b0;
    crc_din    = 1'b0;
    out_b      = 1'b1;
    if (bit_en) begin
      if (ones_q == STUFF_RUN) begin
        tx_d   = 1'b0;
        ones_d = '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            tx_d   = (!raw_mode && fill_flag) ? flag_bit : 1'b1;
            ones_d = '0;
            cnt_d  = byte_last ? '0 : cnt_q + 1'b1;
            if (byte_last) begin
              if (raw_mode) begin
                if (eom_q) begin
                  fifo_flush = 1'b1;
                  eom_d      = 1'b0;
                end else if (!fifo_empty) begin
                  fifo_pop = 1'b1;
                  sh_d     = fifo_dout;
                  state_d  = ST_RAW;
                end
              end else if (!fifo_empty && (eom_q || fifo_full)) begin
                crc_init = 1'b1;
                state_d  = ST_OPEN;
              end else if (eom_q) begin
                eom_d = 1'b0;
              end
            end
          end
          ST_OPEN: begin
            tx_d  = flag_bit;
            cnt_d = cnt_q + 1'b1;
            if (byte_last) begin
              fifo_pop = 1'b1;
              sh_d     = fifo_dout;
              cnt_d    = '0;
              state_d  = ST_DATA;
            end
          end
          ST_DATA: begin
            out_b   = sh_q[0];
            tx_d    = out_b;
            crc_upd = 1'b1;
            crc_din = out_b;
            ones_d  = out_b ? ones_q + 3'd1 : '0;
            sh_d    = sh_q >> 1;
            cnt_d   = cnt_q + 1'b1;
            if (byte_last) begin
              cnt_d = '0;
              if (!fifo_empty) begin
                fifo_pop = 1'b1;
                sh_d     = fifo_dout;
              end else begin
                eom_d   = 1'b0;
                state_d = ST_CRC;
              end
            end
          end
          ST_CRC: begin
            out_b     = ~crc_lsb;
            tx_d      = out_b;
            crc_shift = 1'b1;
            ones_d    = out_b ? ones_q + 3'd1 : '0;
            cnt_d     = cnt_q + 1'b1;
            if (cnt_q == CRC_LAST) begin
              cnt_d   = '0;
              state_d = ST_CLOSE;
            end
          end
          ST_CLOSE: begin
            tx_d   = flag_bit;
            ones_d = '0;
            cnt_d  = cnt_q + 1'b1;
            if (byte_last) begin
              cnt_d   = '0;
              state_d = ST_IDLE;
            end
          end
          ST_RAW: begin
            tx_d  = sh_q[0];
            sh_d  = sh_q >> 1;
            cnt_d = cnt_q + 1'b1;
            if (byte_last) begin
              cnt_d = '0;
              if (eom_q) begin
                fifo_flush = 1'b1;
                eom_d      = 1'b0;
                state_d    = ST_IDLE;
              end else if (!fifo_empty && raw_mode) begin
                fifo_pop = 1'b1;
                sh_d     = fifo_dout;
              end else begin
                state_d = ST_IDLE;
              end
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
    if (cmd_rst) begin
      state_d  = ST_IDLE;
      cnt_d    = '0;
      ones_d   = '0;
      eom_d    = 1'b0;
      tx_d     = 1'b1;
      fifo_pop = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ones_q  <= '0;
      eom_q   <= 1'b0;
      tx_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ones_q  <= ones_d;
      eom_q   <= eom_d;
      tx_q    <= tx_d;
    end
  end

  assign tx_bit = tx_q;
endmodule

// File: rtl/hdlc_dual_tx.sv
module hdlc_dual_tx #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int CRC_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_ready,
  output logic              tx_bit
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic              fifo_push, fifo_pop, ser_flush, fifo_flush;
  logic              fifo_empty, fifo_full;
  logic [DATA_W-1:0] fifo_wdata, fifo_dout;
  logic [CNT_W-1:0]  fifo_count;
  logic              raw_mode, fill_flag, cmd_eom, cmd_rst;

  assign tx_ready   = (fifo_count <= CNT_W'(FIFO_DEPTH / 2));
  assign fifo_flush = ser_flush | cmd_rst;

  hdlc_tx_regs #(.DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_ready(tx_ready), .reg_rdata(reg_rdata),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .raw_mode(raw_mode),
    .fill_flag(fill_flag), .cmd_eom(cmd_eom), .cmd_rst(cmd_rst)
  );

  hdlc_tx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(fifo_wdata),
    .pop(fifo_pop), .flush(fifo_flush), .dout(fifo_dout),
    .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
  );

  hdlc_tx_serial #(.DW(DATA_W), .CRCW(CRC_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .raw_mode(raw_mode),
    .fill_flag(fill_flag), .cmd_eom(cmd_eom), .cmd_rst(cmd_rst),
    .fifo_dout(fifo_dout), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_flush(ser_flush), .tx_bit(tx_bit)
  );
endmodule

// File: rtl/hdlc_dual_tx_chk.sv
module hdlc_dual_tx_chk
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          tx_bit,
  input logic          tx_ready,
  input logic          cmd_rst,
  input logic          fifo_pop,
  input logic          fifo_empty,
  input logic [1:0]    reg_addr,
  input logic [7:0]    reg_rdata,
  input logic [CW-1:0] fifo_count
);
  a_r2_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_en) && !$past(cmd_rst)) |-> $stable(tx_bit));

  a_r9_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (tx_ready && fifo_empty));

  a_r10_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CMD) |-> (reg_rdata == 8'h00));

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
endmodule

bind hdlc_dual_tx hdlc_dual_tx_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit),
  .tx_ready(tx_ready), .cmd_rst(cmd_rst), .fifo_pop(fifo_pop),
  .fifo_empty(fifo_empty), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .fifo_count(fifo_count)
);

// File: tb/tb_hdlc_dual_tx.sv
`timescale 1ns/1ps
module tb_hdlc_dual_tx;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd3;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx_ready, tx_bit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit exq[$];
  bit cq[$];
  logic [7:0] fb[$];
  int st_ones;

  always #2.5 clk = ~clk;

  hdlc_dual_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_ready(tx_ready), .tx_bit(tx_bit)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd3;
    @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd3;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
      cq.push_back(tx_bit);
      @(negedge clk);
    end
  endtask

  task automatic add_pat(logic [7:0] p);
    for (int k = 0; k < 8; k++) exq.push_back(p[k]);
  endtask

  task automatic add_stuffed(bit b);
    exq.push_back(b);
    if (b) st_ones++; else st_ones = 0;
    if (st_ones == 5) begin exq.push_back(1'b0); st_ones = 0; end
  endtask

  task automatic add_frame();
    logic [15:0] c;
    bit f;
    c = 16'hFFFF;
    st_ones = 0;
    add_pat(8'h7E);
    foreach (fb[i]) begin
      for (int k = 0; k < 8; k++) begin
        f = c[0] ^ fb[i][k];
        c = c >> 1;
        if (f) c = c ^ 16'h8408;
        add_stuffed(fb[i][k]);
      end
    end
    c = ~c;
    for (int k = 0; k < 16; k++) add_stuffed(c[k]);
    add_pat(8'h7E);
  endtask

  task automatic compare(string req, string what);
    int bi;
    bi = -1;
    foreach (exq[i]) if (bi < 0 && (i >= cq.size() || cq[i] !== exq[i])) bi = i;
    if (bi < 0) chk(1'b1, req, what, 0, 0);
    else begin
      $display("  first mismatch at bit %0d of %0d", bi, exq.size());
      chk(1'b0, req, what, (bi < cq.size()) ? int'(cq[bi]) : -1, int'(exq[bi]));
    end
  endtask

  task automatic fresh(logic [7:0] mode);
    wr(2'd2, 8'h02);
    wr(2'd1, mode);
    exq.delete(); cq.delete(); fb.delete();
  endtask

  task automatic push_fb();
    foreach (fb[i]) wr(2'd0, fb[i]);
  endtask

  task automatic framed_run(bit flagfill, string req, string what);
    logic [7:0] fill;
    fill = flagfill ? 8'h7E : 8'hFF;
    fresh({6'b0, flagfill, 1'b0});
    for (int i = 0; i < 1 + int'($urandom() % 8); i++) fb.push_back(8'($urandom()));
    push_fb();
    add_pat(fill); add_pat(fill);
    strobe(16);
    compare(req, "fill before end-of-message");
    exq.delete(); cq.delete();
    wr(2'd2, 8'h01);
    add_pat(fill); add_frame(); add_pat(fill); add_pat(fill);
    strobe(exq.size());
    compare(req, what);
  endtask

  logic [7:0] rv;
  logic       pre;

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_bit == 1'b1, "R1", "tx_bit after reset", int'(tx_bit), 1);
    chk(tx_ready == 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);
    rd(2'd1, rv);
    chk(rv == 8'h00, "R1", "mode reg after reset", int'(rv), 0);

    // R10 map: mode readback, command reads zero, status bit0
    wr(2'd1, 8'h03);
    rd(2'd1, rv);
    chk(rv == 8'h03, "R10", "mode readback", int'(rv), 3);
    wr(2'd2, 8'h01);
    rd(2'd2, rv);
    chk(rv == 8'h00, "R10", "command reads zero", int'(rv), 0);
    rd(2'd3, rv);
    chk(rv == 8'h01, "R10", "status ready bit", int'(rv), 1);

    // R3 R5 framed frames, mark then flag fill
    framed_run(1'b0, "R3", "framed frame, mark fill");
    framed_run(1'b1, "R5", "framed frame, flag fill");

    // R4 directed stuffing with long ones runs
    fresh(8'h00);
    fb.push_back(8'hFF); fb.push_back(8'hFF); fb.push_back(8'h7E); fb.push_back(8'h1F);
    push_fb();
    wr(2'd2, 8'h01);
    add_pat(8'hFF); add_frame(); add_pat(8'hFF); add_pat(8'hFF);
    strobe(exq.size());
    compare("R4", "zero insertion in ones-heavy frame");

    // R2 R3 random frames, random fill
    for (int t = 0; t < 4; t++) framed_run(1'($urandom()), "R2", "random framed frame");

    // R8 full FIFO starts frame, underrun closes it
    fresh(8'h00);
    for (int i = 0; i < DEPTH; i++) fb.push_back(8'($urandom()));
    push_fb();
    add_pat(8'hFF); add_frame(); add_pat(8'hFF); add_pat(8'hFF);
    strobe(exq.size());
    compare("R8", "full-start frame closed on underrun");

    // R6 raw mode pass-through
    fresh(8'h03);
    for (int i = 0; i < 5; i++) fb.push_back(8'($urandom()));
    push_fb();
    add_pat(8'hFF);
    foreach (fb[i]) add_pat(fb[i]);
    add_pat(8'hFF); add_pat(8'hFF);
    strobe(exq.size());
    compare("R6", "raw bytes unaltered, ones idle");

    // R11 ready level and overflow drop (raw, no strobes)
    fresh(8'h01);
    for (int i = 0; i < DEPTH + 2; i++) begin
      logic [7:0] b;
      b = 8'($urandom());
      if (i < DEPTH) fb.push_back(b);
      wr(2'd0, b);
      pre = ((i + 1 > DEPTH ? DEPTH : i + 1) <= DEPTH / 2);
      chk(tx_ready == pre, "R11", "tx_ready level per push", int'(tx_ready), int'(pre));
    end
    add_pat(8'hFF);
    foreach (fb[i]) add_pat(fb[i]);
    add_pat(8'hFF);
    strobe(exq.size());
    compare("R11", "pushes past full dropped");

    // R7 raw end-of-message halts after byte in flight
    fresh(8'h01);
    for (int i = 0; i < 6; i++) fb.push_back(8'($urandom()));
    push_fb();
    strobe(8 + 16 + 3);
    wr(2'd2, 8'h01);
    add_pat(8'hFF); add_pat(fb[0]); add_pat(fb[1]); add_pat(fb[2]);
    add_pat(8'hFF); add_pat(8'hFF); add_pat(8'hFF);
    strobe(exq.size() - cq.size());
    compare("R7", "raw halt discards queue");
    chk(tx_ready == 1'b1, "R7", "tx_ready after halt", int'(tx_ready), 1);

    // R9 reset command mid-frame
    fresh(8'h00);
    for (int i = 0; i < 12; i++) fb.push_back(8'h00);
    push_fb();
    chk(tx_ready == 1'b0, "R9", "ready low before reset cmd", int'(tx_ready), 0);
    wr(2'd2, 8'h01);
    strobe(20);
    pre = tx_bit;
    repeat (10) @(negedge clk);
    chk(tx_bit == pre, "R2", "line holds without strobe", int'(tx_bit), int'(pre));
    wr(2'd2, 8'h02);
    chk(tx_ready == 1'b1, "R9", "ready after reset cmd", int'(tx_ready), 1);
    chk(tx_bit == 1'b1, "R9", "line at mark after reset cmd", int'(tx_bit), 1);
    exq.delete(); cq.delete();
    add_pat(8'hFF); add_pat(8'hFF); add_pat(8'hFF);
    strobe(exq.size());
    compare("R9", "fifo emptied, only fill follows");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule